// File: doc/BRIEF.md
# Polarity-Aware GPIO Port Controller

This block controls a port of general-purpose I/O lines (eight by default) through a small byte-wide register interface. Each line has its own direction bit, polarity bit and output latch bit. The block drives the pad cell's output-enable and output-value controls directly. Pad inputs pass through a multi-flop synchronizer. Software can read them back with the polarity correction applied. A sticky per-line flag records each asserting edge of a line.

Each polarity bit does two jobs. It inverts the level driven onto an output line, and it chooses which pad edge sets that line's flag. The output register reads back the latched value, not the pad level, so software can compare it with the input readback to find a line that is being driven against.

The programmable registers have two reset sources. Power-on reset is asynchronous and always clears them. Platform reset is synchronous, and a strap input decides whether it clears them or is ignored.

Top module: `pgio_port`

## Requirements
- R1: After power-on reset, the direction, polarity, output and status registers read 0, and every `padOe` bit is 0.
- R2: Direction register (address 0). Bit value 1 makes the line an output (`padOe` bit = 1). Bit value 0 makes it an input (`padOe` bit = 0). `padOe` takes the new value at the clock edge that samples the write strobe.
- R3: `padOut` bit = output-latch bit XOR polarity bit. A latch bit of 1 asserts the line: it drives 1 with polarity 0 and 0 with polarity 1. A latch bit of 0 drives the opposite level.
- R4: Writes to addresses 0 (direction), 1 (polarity) and 2 (output latch) take effect at the clock edge that samples `wrEn`, and `rdData` returns the stored byte at that address. Reading address 2 returns the latched value whatever level the pad has.
- R5: Address 3 reads the synchronized pad levels XOR the polarity register. A pad change shows there after the second rising clock edge. Writes to address 3 have no effect.
- R6: With polarity 0, a rising pad edge sets that line's status bit (address 4). With polarity 1, a falling pad edge sets it. An edge in the other direction does not set it. The bit sets at the third rising clock edge after the pad change.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: When `keepOnPlatRst` = 0, asserting `platRst` at a clock edge clears the direction, polarity, output and status registers. This takes priority over a write in the same cycle.
- R9: When `keepOnPlatRst` = 1, `platRst` has no effect on any register.
- R10: Changing a polarity bit while the pad is steady does not set that line's status bit.
- R11: Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| platRst | input | 1 | Synchronous platform reset, active high |
| keepOnPlatRst | input | 1 | Strap: 1 makes the registers ignore `platRst` |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOe | output | 8 | Pad output enable per line |
| padOut | output | 8 | Pad output value per line |

## Verification
Register writes, `padOe`, `padOut` and both resets must show their result at the falling edge after the single rising edge that samples the stimulus. The input readback must still hold its old value one edge after a pad change and show the new value after the second edge. A status bit must stay clear after the second edge and be set after the third. The bench drives every input at a falling edge and checks at the falling edge after the counted number of rising edges, including the edge just before each result is due, so a result that arrives one cycle early or late is reported. For the case where a set and a clear collide, the clear strobe is placed exactly on the rising edge where the detected edge sets the flag.

// File: rtl/pgio_pkg.sv
package pgio_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 3'd0,
    SEL_POL  = 3'd1,
    SEL_OUT  = 3'd2,
    SEL_IN   = 3'd3,
    SEL_STAT = 3'd4,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrPol;
    logic    wrOut;
    logic    clrStat;
    logic    clearRegs;
    regSel_e rdSel;
  } pgioStrb_t;

endpackage

// File: rtl/pgio_ctrl.sv
module pgio_ctrl
  import pgio_pkg::*;
(
  input  logic              platRst,
  input  logic              keepOnPlatRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output pgioStrb_t         strb
);

  regSel_e decSel;

  always_comb begin
    unique case (addr)
      3'd0:    decSel = SEL_DIR;
      3'd1:    decSel = SEL_POL;
      3'd2:    decSel = SEL_OUT;
      3'd3:    decSel = SEL_IN;
      3'd4:    decSel = SEL_STAT;
      default: decSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.clearRegs = platRst & ~keepOnPlatRst;
    strb.rdSel     = decSel;
    strb.wrDir     = wrEn & (decSel == SEL_DIR);
    strb.wrPol     = wrEn & (decSel == SEL_POL);
    strb.wrOut     = wrEn & (decSel == SEL_OUT);
    strb.clrStat   = wrEn & (decSel == SEL_STAT);
  end

endmodule

// File: rtl/pgio_datapath.sv
module pgio_datapath
  import pgio_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  pgioStrb_t        strb,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] padIn,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] padOe,
  output logic [LINES-1:0] padOut
);

  logic [LINES-1:0] dirReg, polReg, outReg, statReg;
  logic [LINES-1:0] syncChain [SYNC_STAGES];
  logic [LINES-1:0] syncNow, syncPrev, edgeHit;

  // programmable registers: power-on async, platform sync (priority)
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      dirReg <= '0;
      polReg <= '0;
      outReg <= '0;
    end else if (strb.clearRegs) begin
      dirReg <= '0;
      polReg <= '0;
      outReg <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wrData;
      if (strb.wrPol) polReg <= wrData;
      if (strb.wrOut) outReg <= wrData;
    end
  end

  // input synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= padIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) syncPrev <= '0;
    else          syncPrev <= syncNow;
  end

  // edge selection per line from the raw synchronized level
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_edge
      always_comb begin
        if (polReg[i]) edgeHit[i] = syncPrev[i] & ~syncNow[i];
        else           edgeHit[i] = ~syncPrev[i] & syncNow[i];
      end
    end
  endgenerate

  // sticky status, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            statReg <= '0;
    else if (strb.clearRegs) statReg <= '0;
    else if (strb.clrStat)   statReg <= (statReg & ~wrData) | edgeHit;
    else                     statReg <= statReg | edgeHit;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_DIR:  rdData = dirReg;
      SEL_POL:  rdData = polReg;
      SEL_OUT:  rdData = outReg;
      SEL_IN:   rdData = syncNow ^ polReg;
      SEL_STAT: rdData = statReg;
      default:  rdData = '0;
    endcase
  end

  assign padOe  = dirReg;
  assign padOut = outReg ^ polReg;

  // R7: a set status bit only drops through a clear strobe or a register reset
  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (!strb.clrStat && !strb.clearRegs) |=> ((statReg & $past(statReg)) == $past(statReg)));

  // R10: a newly set bit needs a change of its synchronized input in the prior cycle
  assert_flag_needs_change_R10: assert property (@(posedge clk) disable iff (!porRstN)
    1'b1 |=> ((statReg & ~$past(statReg) & ~$past(syncNow ^ syncPrev)) == '0));

endmodule

// File: rtl/pgio_port.sv
module pgio_port
  import pgio_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              platRst,
  input  logic              keepOnPlatRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [LINES-1:0]  wrData,
  output logic [LINES-1:0]  rdData,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  padOe,
  output logic [LINES-1:0]  padOut
);

  pgioStrb_t strb;

  pgio_ctrl i_ctrl (
    .platRst       (platRst),
    .keepOnPlatRst (keepOnPlatRst),
    .addr          (addr),
    .wrEn          (wrEn),
    .strb          (strb)
  );

  pgio_datapath #(
    .LINES       (LINES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk     (clk),
    .porRstN (porRstN),
    .strb    (strb),
    .wrData  (wrData),
    .padIn   (padIn),
    .rdData  (rdData),
    .padOe   (padOe),
    .padOut  (padOut)
  );

  // R2: a direction write reaches padOe on the sampling edge
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && addr == 3'd0 && !(platRst && !keepOnPlatRst)) |=> (padOe == $past(wrData)));

  // R8: platform reset with strap 0 clears the pad controls
  assert_plat_clear_R8: assert property (@(posedge clk) disable iff (!porRstN)
    (platRst && !keepOnPlatRst) |=> (padOe == '0 && padOut == '0));

  // R9: platform reset with strap 1 and no write leaves the pad controls unchanged
  assert_plat_ignored_R9: assert property (@(posedge clk) disable iff (!porRstN)
    (platRst && keepOnPlatRst && !wrEn) |=> ($stable(padOe) && $stable(padOut)));

endmodule

// File: tb/test_pgio_port.sv
module test_pgio_port;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       platRst = 1'b0;
  logic       keepOnPlatRst = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgio_port i_pgio_port (
    .clk(clk), .porRstN(porRstN), .platRst(platRst), .keepOnPlatRst(keepOnPlatRst),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      if (a == 3) continue;
      rd(a[2:0], v);
      chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset padOe", padOe, 8'h00);
  endtask

  task automatic t_dir_out();
    logic [7:0] v;
    wr(3'd0, 8'hA5);
    chk("R2 padOe after dir write", padOe, 8'hA5);
    rd(3'd0, v); chk("R4 dir readback", v, 8'hA5);
    wr(3'd2, 8'h3C);
    chk("R3 padOut no inversion", padOut, 8'h3C);
    wr(3'd1, 8'h0F);
    chk("R3 padOut with inversion", padOut, 8'h33);
    rd(3'd1, v); chk("R4 pol readback", v, 8'h0F);
    rd(3'd2, v); chk("R4 out readback", v, 8'h3C);
    wr(3'd0, 8'h00);
    chk("R2 padOe off", padOe, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    @(negedge clk); padIn = 8'h00;
    wr(3'd2, 8'hFF);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R4 out latch not pad", v, 8'hFF);
    rd(3'd3, v); chk("R5 input shows pad", v, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] v;
    wr(3'd1, 8'hF0);
    @(negedge clk); padIn = 8'h81;
    @(negedge clk);
    rd(3'd3, v); chk("R5 input one edge (old)", v, 8'hF0);
    @(negedge clk);
    rd(3'd3, v); chk("R5 input two edges", v, 8'h71);
    wr(3'd3, 8'h55);
    rd(3'd3, v); chk("R5 write to input ignored", v, 8'h71);
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'h00);
    @(negedge clk); padIn = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'hFF);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(3'd1, 8'h0F);
    @(negedge clk); padIn = 8'h0F;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R6 status start clear", v, 8'h00);
    @(negedge clk); padIn = 8'hF0;
    repeat (2) @(negedge clk);
    rd(3'd4, v); chk("R6 status not yet at two edges", v, 8'h00);
    @(negedge clk);
    rd(3'd4, v); chk("R6 rise on plain, fall on inverted", v, 8'hFF);
    wr(3'd4, 8'h0F);
    rd(3'd4, v); chk("R7 partial clear", v, 8'hF0);
    @(negedge clk); padIn = 8'h0F;
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R6 wrong-direction edges ignored", v, 8'hF0);
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'h00);
    @(negedge clk); padIn = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'hFF);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    @(negedge clk); padIn = 8'h01;
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 flag set", v, 8'h01);
    @(negedge clk); padIn = 8'h00;
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 sticky after pad drops", v, 8'h01);
    @(negedge clk); padIn = 8'h01;
    @(negedge clk);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R7 set wins over clear", v, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R7 clear", v, 8'h00);
  endtask

  task automatic t_pol_change();
    logic [7:0] v;
    wr(3'd1, 8'hFF);
    repeat (3) @(negedge clk);
    wr(3'd1, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R10 pol change sets no flag", v, 8'h00);
    @(negedge clk); padIn = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'hFF);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(3'd0, 8'h12); wr(3'd1, 8'h00); wr(3'd2, 8'h34);
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF);
      rd(a[2:0], v); chk("R11 unmapped reads 0", v, 8'h00);
    end
    rd(3'd0, v); chk("R11 dir untouched", v, 8'h12);
    rd(3'd2, v); chk("R11 out untouched", v, 8'h34);
    rd(3'd4, v); chk("R11 status untouched", v, 8'h00);
  endtask

  task automatic t_plat(input logic strap);
    logic [7:0] v;
    wr(3'd0, 8'hC3); wr(3'd1, 8'h11); wr(3'd2, 8'h22);
    @(negedge clk); padIn = 8'h01;
    repeat (4) @(negedge clk);
    @(negedge clk); keepOnPlatRst = strap; platRst = 1'b1;
    @(negedge clk); platRst = 1'b0;
    if (strap) begin
      rd(3'd0, v); chk("R9 dir kept", v, 8'hC3);
      rd(3'd1, v); chk("R9 pol kept", v, 8'h11);
      rd(3'd2, v); chk("R9 out kept", v, 8'h22);
      rd(3'd4, v); chk("R9 status kept", v, 8'h00);
      chk("R9 padOe kept", padOe, 8'hC3);
    end else begin
      rd(3'd0, v); chk("R8 dir cleared", v, 8'h00);
      rd(3'd1, v); chk("R8 pol cleared", v, 8'h00);
      rd(3'd2, v); chk("R8 out cleared", v, 8'h00);
      rd(3'd4, v); chk("R8 status cleared", v, 8'h00);
      chk("R8 padOe cleared", padOe, 8'h00);
    end
    keepOnPlatRst = 1'b0;
    wr(3'd1, 8'h00);
    @(negedge clk); padIn = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'hFF);
  endtask

  task automatic t_plat_priority();
    logic [7:0] v;
    @(negedge clk); addr = 3'd0; wrData = 8'hFF; wrEn = 1'b1; platRst = 1'b1;
    @(negedge clk); wrEn = 1'b0; platRst = 1'b0;
    rd(3'd0, v); chk("R8 clear beats write", v, 8'h00);
  endtask

  initial begin
    #20000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_conflict();
    t_input();
    t_edges();
    t_set_wins();
    t_pol_change();
    t_unmapped();
    t_plat(1'b0);
    t_plat(1'b1);
    t_plat_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule